// File: doc/BRIEF.md
# Instruction Address Compare Unit

This block watches the stream of instruction fetch attempts from a processor core. It raises a debug event when an attempted instruction address meets the criteria programmed into a small bank of compare registers. There are four address registers, grouped as two pairs. Each pair works in one of four modes:

- **Exact:** the two registers are compared separately against the address.
- **Masked:** the second register is a bit mask for the first.
- **Inclusive range:** the two registers are the low and high bounds, and the address must lie between them.
- **Exclusive range:** the two registers are the low and high bounds, and the address must lie outside them.

A compare can also require a given privilege level and a given instruction-space bit.

The unit only evaluates genuine execution attempts. An attempt that will not start because an exception of higher priority is pending at that boundary produces no event. The debug logic consumes the events as one-cycle pulses, one bit per comparator. These pulses come from a register and appear on the clock edge that samples the fetch strobe.

Top module: `iac_unit`

## Requirements
- R1: While `rst_n` is low, `evt_o` is all zeros on the cycle after each clock edge.
- R2: In exact mode (`pair_mode_i[p]` = 2'b00), comparator k raises `evt_o[k]` when all of the following hold: it is enabled, `fetch_addr_i` equals `cmp_addr_i[k]`, and the fetch is valid. The pulse is visible after the edge that samples `fetch_vld_i`, and it lasts one cycle when the strobe drops.
- R3: A comparator whose bit in `cmp_en_i` is 0 never raises an event. In a paired mode (`pair_mode_i[p]` != 2'b00), only the enable bit of the lower comparator 2p governs the pair.
- R4: In masked mode (`pair_mode_i[p]` = 2'b01), comparator 2p matches when the address equals `cmp_addr_i[2p]` in every bit where `cmp_addr_i[2p+1]` is 1. Bits where the mask is 0 are ignored. `evt_o[2p+1]` stays 0 in this mode.
- R5: In inclusive range mode (`pair_mode_i[p]` = 2'b10), a match occurs when `cmp_addr_i[2p]` <= address <= `cmp_addr_i[2p+1]` (unsigned). On a match, both `evt_o[2p]` and `evt_o[2p+1]` rise.
- R6: In exclusive range mode (`pair_mode_i[p]` = 2'b11), a match occurs when the address is below `cmp_addr_i[2p]` or above `cmp_addr_i[2p+1]`. On a match, both event bits of the pair rise.
- R7: The privilege qualifier `priv_q_i[k]` has three encodings. With 2'b0x it is ignored. With 2'b10 it requires `fetch_user_i` = 0 (supervisor). With 2'b11 it requires `fetch_user_i` = 1 (user). In paired modes, the qualifier of comparator 2p applies.
- R8: The space qualifier `space_q_i[k]` uses the same encoding as R7, applied to `fetch_space_i`.
- R9: A fetch sampled with `exc_pend_i` = 1 produces no event on any comparator.
- R10: A cycle with `fetch_vld_i` = 0 produces no event, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld_i | input | 1 | An instruction execution attempt is presented this cycle |
| fetch_addr_i | input | ADDR_W | Effective address of the attempted instruction |
| fetch_user_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| fetch_space_i | input | 1 | Instruction-space bit of the attempt |
| exc_pend_i | input | 1 | A higher-priority exception is pending at this boundary |
| cmp_en_i | input | 2*NUM_PAIRS | Per-comparator enable |
| pair_mode_i | input | NUM_PAIRS x 2 | Pair mode: 00 exact, 01 masked, 10 inclusive range, 11 exclusive range |
| priv_q_i | input | 2*NUM_PAIRS x 2 | Per-comparator privilege qualifier |
| space_q_i | input | 2*NUM_PAIRS x 2 | Per-comparator space qualifier |
| cmp_addr_i | input | 2*NUM_PAIRS x ADDR_W | Compare address registers |
| evt_o | output | 2*NUM_PAIRS | Per-comparator event pulse |

## Verification
The bench builds the unit with `ADDR_W` = 16 and the default two pairs, which gives the four comparators under test. The narrower address keeps the test values short. It still lets range bounds be placed exactly at the test points, so the bench can probe one below and one above each bound. Both pairs are exercised, so the bench also covers one pair running in exact mode while the other runs a range mode.

// File: rtl/iac_pkg.sv
// Package: shared encodings for the instruction address compare unit.
// Assumes qualifier fields are two bits wide, with the upper bit as "enforce".
package iac_pkg;

    typedef enum logic [1:0] {
        PM_EXACT     = 2'b00,
        PM_MASKED    = 2'b01,
        PM_RANGE_IN  = 2'b10,
        PM_RANGE_OUT = 2'b11
    } pair_mode_e;

    // Qualifier passes if not enforced, or if the observed bit equals the required value.
    function automatic logic qual_pass(input logic [1:0] q, input logic obs);
        return (q[1] == 1'b0) || (q[0] == obs);
    endfunction

endpackage

// File: rtl/iac_qual.sv
// Module: iac_qual
// Combines the privilege and space qualifiers of one comparator into a single pass flag.
// Assumes the encoding from iac_pkg: 0x = ignore, 10 = must be 0, 11 = must be 1.
module iac_qual (
    input  logic [1:0] priv_q,
    input  logic [1:0] space_q,
    input  logic       user_bit,
    input  logic       space_bit,
    output logic       pass
);
    import iac_pkg::*;

    // Both qualifiers must pass.
    always_comb begin
        pass = qual_pass(priv_q, user_bit) && qual_pass(space_q, space_bit);
    end

endmodule

// File: rtl/iac_pair.sv
// Module: iac_pair
// Evaluates one pair of compare registers against the fetch address under the pair mode.
// Purely combinational; the parent registers the result and applies fetch gating.
// Assumes index 0 is the lower comparator (address or low bound) and index 1 the upper
// (mask or high bound); in paired modes comparator 0's enable and qualifiers govern.
module iac_pair #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   user_bit,
    input  logic                   space_bit,
    input  logic [1:0]             mode,
    input  logic [1:0]             en,
    input  logic [1:0][1:0]        priv_q,
    input  logic [1:0][1:0]        space_q,
    input  logic [1:0][ADDR_W-1:0] ref_addr,
    output logic [1:0]             hit
);
    import iac_pkg::*;

    logic [1:0] q_ok;
    logic       eq_lo;
    logic       eq_hi;
    logic       mask_eq;
    logic       ge_lo;
    logic       le_hi;
    logic       in_win;
    logic       out_win;

    // One qualifier block per comparator of the pair.
    for (genvar k = 0; k < 2; k++) begin : g_q
        iac_qual u_q (
            .priv_q    (priv_q[k]),
            .space_q   (space_q[k]),
            .user_bit  (user_bit),
            .space_bit (space_bit),
            .pass      (q_ok[k])
        );
    end

    // Raw address relations shared by all modes.
    always_comb begin
        eq_lo   = (addr == ref_addr[0]);
        eq_hi   = (addr == ref_addr[1]);
        mask_eq = (((addr ^ ref_addr[0]) & ref_addr[1]) == '0);
        ge_lo   = (addr >= ref_addr[0]);
        le_hi   = (addr <= ref_addr[1]);
        in_win  = ge_lo && le_hi;
        out_win = !ge_lo || !le_hi;
    end

    // Select the hit vector according to the pair mode.
    always_comb begin
        unique case (pair_mode_e'(mode))
            PM_EXACT:     hit = {en[1] && q_ok[1] && eq_hi, en[0] && q_ok[0] && eq_lo};
            PM_MASKED:    hit = {1'b0, en[0] && q_ok[0] && mask_eq};
            PM_RANGE_IN:  hit = {2{en[0] && q_ok[0] && in_win}};
            PM_RANGE_OUT: hit = {2{en[0] && q_ok[0] && out_win}};
            default:      hit = '0;
        endcase
    end

endmodule

// File: rtl/iac_unit.sv
// Module: iac_unit (top)
// Instruction address compare unit: 2*NUM_PAIRS comparators arranged in pairs, each pair
// exact, masked or range (inclusive/exclusive), with privilege and space qualifiers.
// Events are registered one-cycle pulses for a valid fetch with no pending exception.
// Assumes configuration inputs are stable around each sampled fetch.
module iac_unit #(
    parameter int ADDR_W    = 32,
    parameter int NUM_PAIRS = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 fetch_vld_i,
    input  logic [ADDR_W-1:0]                    fetch_addr_i,
    input  logic                                 fetch_user_i,
    input  logic                                 fetch_space_i,
    input  logic                                 exc_pend_i,
    input  logic [2*NUM_PAIRS-1:0]               cmp_en_i,
    input  logic [NUM_PAIRS-1:0][1:0]            pair_mode_i,
    input  logic [2*NUM_PAIRS-1:0][1:0]          priv_q_i,
    input  logic [2*NUM_PAIRS-1:0][1:0]          space_q_i,
    input  logic [2*NUM_PAIRS-1:0][ADDR_W-1:0]   cmp_addr_i,
    output logic [2*NUM_PAIRS-1:0]               evt_o
);
    localparam int NUM_CMP = 2 * NUM_PAIRS;

    logic [NUM_CMP-1:0] hit_raw;
    logic               take;

    // One evaluator per comparator pair.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        iac_pair #(.ADDR_W(ADDR_W)) u_pair (
            .addr      (fetch_addr_i),
            .user_bit  (fetch_user_i),
            .space_bit (fetch_space_i),
            .mode      (pair_mode_i[p]),
            .en        (cmp_en_i[2*p +: 2]),
            .priv_q    (priv_q_i[2*p +: 2]),
            .space_q   (space_q_i[2*p +: 2]),
            .ref_addr  (cmp_addr_i[2*p +: 2]),
            .hit       (hit_raw[2*p +: 2])
        );
    end

    // A fetch counts only if it is valid and not pre-empted by an exception.
    always_comb begin
        take = fetch_vld_i && !exc_pend_i;
    end

    // Register the gated hits as event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_o <= '0;
        end else begin
            evt_o <= take ? hit_raw : '0;
        end
    end

endmodule

// File: rtl/iac_unit_chk.sv
// Module: iac_unit_chk
// Property checker bound to iac_unit; observes ports only.
module iac_unit_chk #(
    parameter int ADDR_W    = 32,
    parameter int NUM_PAIRS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        fetch_vld_i,
    input logic                        exc_pend_i,
    input logic [2*NUM_PAIRS-1:0]      cmp_en_i,
    input logic [NUM_PAIRS-1:0][1:0]   pair_mode_i,
    input logic [2*NUM_PAIRS-1:0]      evt_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> evt_o == '0); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld_i |=> evt_o == '0); // R10
    AST_EXC_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend_i |=> evt_o == '0); // R9

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
        AST_LOWER_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !cmp_en_i[2*p] |=> !evt_o[2*p]); // R3
        AST_MASK_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            pair_mode_i[p] == 2'b01 |=> !evt_o[2*p+1]); // R4
        AST_RANGE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
            pair_mode_i[p][1] |=> evt_o[2*p] == evt_o[2*p+1]); // R5
    end
endmodule

bind iac_unit iac_unit_chk #(.ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_vld_i (fetch_vld_i),
    .exc_pend_i  (exc_pend_i),
    .cmp_en_i    (cmp_en_i),
    .pair_mode_i (pair_mode_i),
    .evt_o       (evt_o)
);

// File: tb/iac_unit_tb_top.sv
`timescale 1ns/1ps
module iac_unit_tb_top;
    localparam int AW = 16;
    localparam int NP = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                f_vld = 1'b0;
    logic [AW-1:0]       f_addr = '0;
    logic                f_user = 1'b0;
    logic                f_space = 1'b0;
    logic                f_exc = 1'b0;
    logic [3:0]          en = '0;
    logic [1:0][1:0]     mode = '0;
    logic [3:0][1:0]     pq = '0;
    logic [3:0][1:0]     sq = '0;
    logic [3:0][AW-1:0]  ra = '0;
    logic [3:0]          evt;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    iac_unit #(.ADDR_W(AW), .NUM_PAIRS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_vld_i(f_vld), .fetch_addr_i(f_addr),
        .fetch_user_i(f_user), .fetch_space_i(f_space), .exc_pend_i(f_exc),
        .cmp_en_i(en), .pair_mode_i(mode), .priv_q_i(pq), .space_q_i(sq),
        .cmp_addr_i(ra), .evt_o(evt)
    );

    task automatic chk(input logic [3:0] exp, input string tag);
        n_chk++;
        if (evt !== exp) begin
            n_bad++;
            $display("FAIL %s: evt_o=%b expected %b", tag, evt, exp);
        end
    endtask

    // One fetch attempt; checks the pulse after the sampling edge.
    task automatic fire(input logic [AW-1:0] a, input logic u, input logic s,
                        input logic x, input logic [3:0] exp, input string tag);
        @(negedge clk);
        f_addr = a; f_user = u; f_space = s; f_exc = x; f_vld = 1'b1;
        @(negedge clk);
        f_vld = 1'b0; f_exc = 1'b0;
        chk(exp, tag);
    endtask

    task automatic clear_cfg();
        en = '0; mode = '0; pq = '0; sq = '0; ra = '0;
    endtask

    task automatic t_reset();
        f_vld = 1'b1; f_addr = '0; en = 4'b1111; // would match ra=0 if not in reset
        repeat (3) @(negedge clk);
        chk(4'b0000, "R1 held in reset");
        f_vld = 1'b0; en = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(4'b0000, "R1 after reset release");
    endtask

    task automatic t_exact();
        clear_cfg();
        ra[0] = 16'h1000; en = 4'b0001;
        fire(16'h1000, 0, 0, 0, 4'b0001, "R2 exact hit c0");
        @(negedge clk);
        chk(4'b0000, "R2 pulse one cycle");
        fire(16'h1004, 0, 0, 0, 4'b0000, "R2 exact miss");
        ra[2] = 16'h1000; en = 4'b0101;
        fire(16'h1000, 0, 0, 0, 4'b0101, "R2 exact hit c0 and c2");
        ra[3] = 16'h2222; en = 4'b1101;
        fire(16'h2222, 0, 0, 0, 4'b1000, "R2 exact hit c3");
    endtask

    task automatic t_disabled();
        clear_cfg();
        ra[0] = 16'h1000; ra[1] = 16'h1000; en = 4'b0000;
        fire(16'h1000, 0, 0, 0, 4'b0000, "R3 disabled exact");
        mode[1] = 2'b10; ra[2] = 16'h0000; ra[3] = 16'hFFFF; en = 4'b1000;
        fire(16'h1000, 0, 0, 0, 4'b0000, "R3 range with lower disabled");
    endtask

    task automatic t_idle();
        clear_cfg();
        ra[0] = 16'h1000; en = 4'b0001;
        @(negedge clk); f_addr = 16'h1000; f_vld = 1'b0;
        @(negedge clk); chk(4'b0000, "R10 no strobe cycle 1");
        @(negedge clk); chk(4'b0000, "R10 no strobe cycle 2");
    endtask

    task automatic t_masked();
        clear_cfg();
        mode[0] = 2'b01; ra[0] = 16'h1230; ra[1] = 16'hFFF0; en = 4'b0011;
        fire(16'h123F, 0, 0, 0, 4'b0001, "R4 masked low bits ignored");
        fire(16'h1330, 0, 0, 0, 4'b0000, "R4 masked mismatch");
        fire(16'hFFF0, 0, 0, 0, 4'b0000, "R4 mask register not an exact compare");
    endtask

    task automatic t_range_in();
        clear_cfg();
        mode[1] = 2'b10; ra[2] = 16'h2000; ra[3] = 16'h20FF; en = 4'b0100;
        fire(16'h2000, 0, 0, 0, 4'b1100, "R5 low bound");
        fire(16'h20FF, 0, 0, 0, 4'b1100, "R5 high bound");
        fire(16'h1FFF, 0, 0, 0, 4'b0000, "R5 below");
        fire(16'h2100, 0, 0, 0, 4'b0000, "R5 above");
        ra[0] = 16'h2050; en = 4'b0101;
        fire(16'h2050, 0, 0, 0, 4'b1101, "R5 with exact pair0");
    endtask

    task automatic t_range_out();
        clear_cfg();
        mode[1] = 2'b11; ra[2] = 16'h2000; ra[3] = 16'h20FF; en = 4'b0100;
        fire(16'h1FFF, 0, 0, 0, 4'b1100, "R6 below");
        fire(16'h2100, 0, 0, 0, 4'b1100, "R6 above");
        fire(16'h2000, 0, 0, 0, 4'b0000, "R6 low bound inside");
        fire(16'h2050, 0, 0, 0, 4'b0000, "R6 middle");
    endtask

    task automatic t_priv();
        clear_cfg();
        ra[0] = 16'h3000; en = 4'b0001; pq[0] = 2'b10;
        fire(16'h3000, 0, 0, 0, 4'b0001, "R7 supervisor required, supervisor");
        fire(16'h3000, 1, 0, 0, 4'b0000, "R7 supervisor required, user");
        pq[0] = 2'b11;
        fire(16'h3000, 1, 0, 0, 4'b0001, "R7 user required, user");
        fire(16'h3000, 0, 0, 0, 4'b0000, "R7 user required, supervisor");
        pq[0] = 2'b01;
        fire(16'h3000, 0, 0, 0, 4'b0001, "R7 don't care");
    endtask

    task automatic t_space();
        clear_cfg();
        ra[0] = 16'h3000; en = 4'b0001; sq[0] = 2'b11;
        fire(16'h3000, 0, 1, 0, 4'b0001, "R8 space 1 required, 1");
        fire(16'h3000, 0, 0, 0, 4'b0000, "R8 space 1 required, 0");
        sq[0] = 2'b10;
        fire(16'h3000, 0, 0, 0, 4'b0001, "R8 space 0 required, 0");
        fire(16'h3000, 0, 1, 0, 4'b0000, "R8 space 0 required, 1");
    endtask

    task automatic t_exc();
        clear_cfg();
        ra[0] = 16'h4000; en = 4'b0101;
        mode[1] = 2'b10; ra[2] = 16'h0000; ra[3] = 16'hFFFF;
        fire(16'h4000, 0, 0, 1, 4'b0000, "R9 exception pending");
        fire(16'h4000, 0, 0, 0, 4'b1101, "R9 same fetch without exception");
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        report();
    end

    initial begin
        t_reset();
        t_exact();
        t_disabled();
        t_idle();
        t_masked();
        t_range_in();
        t_range_out();
        t_priv();
        t_space();
        t_exc();
        report();
    end
endmodule